// File: doc/BRIEF.md
# Configuration Start-Up Event Sequencer

This block closes out device configuration. While configuration data arrives, it counts configuration-clock strobes that come after the init indication goes high. It waits for two things: that count must reach a programmed length, and an end-of-frame pulse must have been seen. When both hold, the block enters start-up. In start-up it times three separate events: it stops pulling the open-drain DONE line low, it releases global set/reset, and it enables user I/O.

All logic runs on one clock, `clk`. The rising edges of the configuration clock and of the user clock reach the block as one-cycle strobes. A 2-bit mode selects which strobe times start-up and whether start-up is synchronized. In synchronized modes, the set/reset release and the I/O enable wait for the wired-AND DONE line to read high. They then wait a programmable number of further strobes. Any other device that holds DONE low therefore stalls them. In free-running modes, each event fires on a programmable strobe counted from the start of start-up. A low level on the program request aborts everything and returns the block to its clear state. The mode and timing fields are then captured again.

Top module: `cfg_startup_seq`

## Requirements
- R1: When `rst_n` is low, and from the edge that samples `prog_n` low until the edge that first samples it high again, the outputs are: `done_drive_low`=1, `gsr_active`=1, `io_enable`=0, `io_hiz_req`=1 and `cfg_clear_req`=1. `io_hiz_req` is always the inverse of `io_enable`.
- R2: In the configuring state, a length counter advances on each edge where `init_done` and `cclk_en` are both high. It stops when it equals the captured `len_limit`. Start-up begins on the edge after the count equals the limit and an earlier `frame_end` pulse has been registered. Before start-up, none of the three events occurs.
- R3: `mode_sel[1]`=1 selects the user-clock strobe and `mode_sel[0]`=1 selects synchronized operation. `mode_sel`, `len_limit` and the three slot fields are captured on the edge that leaves the clear state. Later changes to them have no effect until the next clear.
- R4: In every mode, DONE is released on strobe number `done_slot`+1 counted after start-up begins. Slot values 5 to 7 act as 4.
- R5: In free-running modes, set/reset release and I/O enable follow the same rule with `gsr_slot` and `io_slot`.
- R6: In synchronized modes, `done_sense` passes through two flops. With a slot of 0, the event fires on the first edge at which the synchronized level is high. With a slot of N from 1 to 4, it fires on the Nth strobe that sees the synchronized level high.
- R7: While an external device holds `done_sense` low in a synchronized mode, set/reset stays asserted and I/O stays disabled, even though this block has released DONE.
- R8: During start-up only the selected strobe advances the timing: `uclk_en` in user-clock modes and `cclk_en` otherwise. The length count always uses `cclk_en`.
- R9: Each event stays set until the next clear. `startup_done` is high exactly when all three events have occurred.
- R10: `prog_n` sampled low in any state aborts start-up and clears all counts and events. A new start-up then needs a full new length count and a new `frame_end`.
- R11: The three events may occur in any order, including all on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_n | input | 1 | Program request, active low, synchronous |
| mode_sel | input | 2 | [1] user-clock timing, [0] synchronized |
| len_limit | input | LEN_W | Number of configuration strobes before start-up |
| done_slot | input | 3 | Strobe slot for DONE release |
| gsr_slot | input | 3 | Slot or post-DONE delay for set/reset release |
| io_slot | input | 3 | Slot or post-DONE delay for I/O enable |
| init_done | input | 1 | Init indication; length counting enabled while high |
| frame_end | input | 1 | End-of-configuration frame received (pulse) |
| cclk_en | input | 1 | Configuration-clock rising-edge strobe |
| uclk_en | input | 1 | User-clock rising-edge strobe |
| done_sense | input | 1 | Sensed wired-AND level of the DONE line |
| done_drive_low | output | 1 | 1 = pull the open-drain DONE line low |
| gsr_active | output | 1 | Global set/reset asserted |
| io_enable | output | 1 | User I/O active |
| io_hiz_req | output | 1 | Request to hold non-configuration I/O in high impedance |
| cfg_clear_req | output | 1 | Request to clear the configured state |
| startup_done | output | 1 | All three events have occurred |

## Verification
On every cycle, the assertions check the following. The clear state holds all three events off. No event appears before start-up. A program request always lands in the clear state. The length count never passes its limit, and the strobe counters saturate instead of wrapping. A synchronized event never fires while the synchronized DONE level is low, and a free-running event never fires without a strobe. Only the bench scenarios can show the following: the exact strobe on which each event fires, the two-flop delay from a DONE release to the events that depend on it, an external hold stalling start-up, event orders that are reversed or coincident, mode capture at the exit from clear, and the need for a full recount after an abort.

// File: rtl/csq_pkg.sv
package csq_pkg;

  localparam int unsigned SLOT_W = 3;
  localparam int unsigned NUM_EV = 3;
  localparam int unsigned EV_DONE = 0;
  localparam int unsigned EV_GSR  = 1;
  localparam int unsigned EV_IO   = 2;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(4);

  typedef enum logic [1:0] {
    ST_CLEAR  = 2'd0,
    ST_CONFIG = 2'd1,
    ST_RUN    = 2'd2
  } csq_state_e;

  typedef struct packed {
    logic user_clk;
    logic sync;
  } csq_mode_t;

  // Raw slot fields above the last legal slot behave as the last slot.
  function automatic logic [SLOT_W-1:0] slot_clamp(input logic [SLOT_W-1:0] raw);
    return (raw > LAST_SLOT) ? LAST_SLOT : raw;
  endfunction

  // Number of earlier strobes that must have passed before slot s fires.
  function automatic logic [SLOT_W-1:0] slot_prior(input logic [SLOT_W-1:0] s);
    return (s == '0) ? '0 : s - 1'b1;
  endfunction

  function automatic csq_mode_t mode_decode(input logic [1:0] sel);
    csq_mode_t m;
    m.user_clk = sel[1];
    m.sync     = sel[0];
    return m;
  endfunction

endpackage

// File: rtl/csq_len_counter.sv
module csq_len_counter #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [LEN_W-1:0] limit,
  output logic             at_limit
);

  logic [LEN_W-1:0] cnt_q;

  assign at_limit = (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr)               cnt_q <= '0;
    else if (inc && !at_limit)  cnt_q <= cnt_q + 1'b1;
  end

  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && at_limit) |=> (cnt_q == $past(cnt_q)) || $past(limit) != limit);

endmodule

// File: rtl/csq_tick_counter.sv
module csq_tick_counter #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  a_r6_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == TOP) |=> cnt == TOP);

endmodule

// File: rtl/csq_done_sync.sv
module csq_done_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
    end
  end

  assign dout = stage2_q;

endmodule

// File: rtl/csq_event_timer.sv
module csq_event_timer
  import csq_pkg::*;
#(
  parameter bit SYNC_CAPABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic              tick,
  input  logic              sync_mode,
  input  logic              line_high,
  input  logic [SLOT_W-1:0] slot_raw,
  input  logic [SLOT_W-1:0] edge_cnt,
  input  logic [SLOT_W-1:0] post_cnt,
  output logic              fired
);

  logic [SLOT_W-1:0] slot;
  logic              gated;
  logic              free_hit;
  logic              sync_hit;
  logic              fire_now;

  assign slot     = slot_clamp(slot_raw);
  assign gated    = SYNC_CAPABLE && sync_mode;
  assign free_hit = tick && (edge_cnt == slot);
  assign sync_hit = line_high && ((slot == '0) || (tick && post_cnt == slot_prior(slot)));
  assign fire_now = run && (gated ? sync_hit : free_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fired <= 1'b0;
    else if (clr)      fired <= 1'b0;
    else if (fire_now) fired <= 1'b1;
  end

  a_r6_waits_for_line: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && !line_high && !fired) |=> !fired);

  a_r5_free_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!gated && !tick && !fired) |=> !fired);

endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
  import csq_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_n,
  input  logic [1:0]       mode_sel,
  input  logic [LEN_W-1:0] len_limit,
  input  logic [2:0]       done_slot,
  input  logic [2:0]       gsr_slot,
  input  logic [2:0]       io_slot,
  input  logic             init_done,
  input  logic             frame_end,
  input  logic             cclk_en,
  input  logic             uclk_en,
  input  logic             done_sense,
  output logic             done_drive_low,
  output logic             gsr_active,
  output logic             io_enable,
  output logic             io_hiz_req,
  output logic             cfg_clear_req,
  output logic             startup_done
);

  csq_state_e        state_q;
  csq_mode_t         mode_q;
  logic [LEN_W-1:0]  len_q;
  logic [SLOT_W-1:0] slot_q  [NUM_EV];
  logic [SLOT_W-1:0] slot_in [NUM_EV];
  logic              frame_q;

  // Named internal events, visible to the assertions.
  logic              clr;
  logic              leave_clear;
  logic              run;
  logic              tick;
  logic              at_limit;
  logic              start_now;
  logic              line_sync;
  logic [SLOT_W-1:0] edge_cnt;
  logic [SLOT_W-1:0] post_cnt;
  logic [NUM_EV-1:0] fired;

  assign slot_in[EV_DONE] = done_slot;
  assign slot_in[EV_GSR]  = gsr_slot;
  assign slot_in[EV_IO]   = io_slot;

  assign clr         = !prog_n || (state_q == ST_CLEAR);
  assign leave_clear = prog_n && (state_q == ST_CLEAR);
  assign run         = (state_q == ST_RUN);
  assign tick        = mode_q.user_clk ? uclk_en : cclk_en;
  assign start_now   = (state_q == ST_CONFIG) && at_limit && frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CLEAR;
    end else if (!prog_n) begin
      state_q <= ST_CLEAR;
    end else begin
      unique case (state_q)
        ST_CLEAR:  state_q <= ST_CONFIG;
        ST_CONFIG: if (start_now) state_q <= ST_RUN;
        default:   state_q <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= mode_decode(2'b01);
      len_q  <= '0;
      for (int i = 0; i < NUM_EV; i++) slot_q[i] <= '0;
    end else if (leave_clear) begin
      mode_q <= mode_decode(mode_sel);
      len_q  <= len_limit;
      for (int i = 0; i < NUM_EV; i++) slot_q[i] <= slot_in[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    frame_q <= 1'b0;
    else if (clr)                                  frame_q <= 1'b0;
    else if (state_q == ST_CONFIG && frame_end)    frame_q <= 1'b1;
  end

  csq_len_counter #(.LEN_W(LEN_W)) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .inc      ((state_q == ST_CONFIG) && init_done && cclk_en),
    .limit    (len_q),
    .at_limit (at_limit)
  );

  csq_done_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (done_sense),
    .dout  (line_sync)
  );

  csq_tick_counter #(.W(SLOT_W)) u_edge_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .inc   (run && tick),
    .cnt   (edge_cnt)
  );

  csq_tick_counter #(.W(SLOT_W)) u_post_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .inc   (run && tick && line_sync),
    .cnt   (post_cnt)
  );

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    csq_event_timer #(.SYNC_CAPABLE(g != EV_DONE)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .run       (run),
      .tick      (tick),
      .sync_mode (mode_q.sync),
      .line_high (line_sync),
      .slot_raw  (slot_q[g]),
      .edge_cnt  (edge_cnt),
      .post_cnt  (post_cnt),
      .fired     (fired[g])
    );
  end

  assign done_drive_low = !fired[EV_DONE];
  assign gsr_active     = !fired[EV_GSR];
  assign io_enable      = fired[EV_IO];
  assign io_hiz_req     = !fired[EV_IO];
  assign cfg_clear_req  = (state_q == ST_CLEAR);
  assign startup_done   = &fired;

  a_r1_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CLEAR) |-> (fired == '0));

  a_r2_idle_until_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN) |-> (fired == '0));

  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |=> (state_q == ST_CLEAR) && (fired == '0));

  a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (startup_done && prog_n) |=> startup_done);

endmodule

// File: tb/tb_cfg_startup_seq.sv
module tb_cfg_startup_seq;

  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_n = 1'b1;
  logic [1:0] mode_sel = 2'b01;
  logic [LEN_W-1:0] len_limit = '0;
  logic [2:0] done_slot = '0, gsr_slot = '0, io_slot = '0;
  logic init_done = 1'b0, frame_end = 1'b0;
  logic cclk_en = 1'b0, uclk_en = 1'b0;
  logic ext_hold = 1'b0;
  logic done_sense;
  logic done_drive_low, gsr_active, io_enable, io_hiz_req, cfg_clear_req, startup_done;

  int n_checks = 0, n_err = 0, cyc = 0, ph = 0;
  bit cc_on = 0, uc_on = 0;

  assign done_sense = !done_drive_low && !ext_hold;

  always #5 clk = !clk;

  cfg_startup_seq #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .mode_sel(mode_sel),
    .len_limit(len_limit), .done_slot(done_slot), .gsr_slot(gsr_slot),
    .io_slot(io_slot), .init_done(init_done), .frame_end(frame_end),
    .cclk_en(cclk_en), .uclk_en(uclk_en), .done_sense(done_sense),
    .done_drive_low(done_drive_low), .gsr_active(gsr_active),
    .io_enable(io_enable), .io_hiz_req(io_hiz_req),
    .cfg_clear_req(cfg_clear_req), .startup_done(startup_done));

  // Behavioural reference: phase 0 clear, 1 configuring, 2 start-up.
  int m_ph = 0, m_cnt = 0, m_lim = 0, m_since = 0, m_after = 0;
  bit m_frame = 0, m_user = 0, m_sync = 1, m_l1 = 0, m_l2 = 0;
  bit m_ev[3] = '{0, 0, 0};
  int m_sl[3] = '{0, 0, 0};

  function automatic int eff_slot(int raw);
    if (raw >= 5) return 4;
    return raw;
  endfunction

  always @(posedge clk) begin
    bit line, nl1, nl2, stb, go;
    bit hit[3];
    line = m_ev[0] && !ext_hold;
    nl1 = line;
    nl2 = m_l1;
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_lim = 0; m_frame = 0; m_since = 0; m_after = 0;
      m_user = 0; m_sync = 1; m_ev = '{0, 0, 0}; m_sl = '{0, 0, 0};
      nl1 = 0; nl2 = 0;
    end else if (!prog_n) begin
      m_ph = 0; m_cnt = 0; m_frame = 0; m_since = 0; m_after = 0; m_ev = '{0, 0, 0};
    end else if (m_ph == 0) begin
      m_ph = 1; m_user = mode_sel[1]; m_sync = mode_sel[0]; m_lim = int'(len_limit);
      m_sl[0] = int'(done_slot); m_sl[1] = int'(gsr_slot); m_sl[2] = int'(io_slot);
      m_cnt = 0; m_frame = 0; m_since = 0; m_after = 0; m_ev = '{0, 0, 0};
    end else if (m_ph == 1) begin
      go = (m_cnt == m_lim) && m_frame;
      if (frame_end) m_frame = 1;
      if (init_done && cclk_en && m_cnt != m_lim) m_cnt++;
      if (go) m_ph = 2;
    end else begin
      stb = m_user ? uclk_en : cclk_en;
      for (int e = 0; e < 3; e++) begin
        int s;
        s = eff_slot(m_sl[e]);
        if (e != 0 && m_sync) hit[e] = m_l2 && (s == 0 || (stb && m_after == s - 1));
        else hit[e] = stb && (m_since == s);
      end
      for (int e = 0; e < 3; e++) if (hit[e]) m_ev[e] = 1;
      if (stb && m_l2 && m_after < 7) m_after++;
      if (stb && m_since < 7) m_since++;
    end
    m_l1 = nl1;
    m_l2 = nl2;
  end

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    string dep;
    dep = m_sync ? "R6" : "R5";
    check("R1 clear request", cfg_clear_req, m_ph == 0);
    check("R1 hiz request", io_hiz_req, !m_ev[2]);
    check("R4 done", done_drive_low, !m_ev[0]);
    check({dep, " gsr"}, gsr_active, !m_ev[1]);
    check({dep, " io"}, io_enable, m_ev[2]);
    check("R9 status", startup_done, m_ev[0] && m_ev[1] && m_ev[2]);
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare_all();
      ph++;
      cclk_en = cc_on && (ph % 3 != 1);
      uclk_en = uc_on && (ph % 4 == 0);
    end
  endtask

  task automatic begin_cfg(input logic [1:0] md, input int len, input int ds, input int gs, input int is);
    mode_sel = md; len_limit = LEN_W'(len);
    done_slot = 3'(ds); gsr_slot = 3'(gs); io_slot = 3'(is);
    prog_n = 0; init_done = 0;
    step(2);
    prog_n = 1;
    step(1);
    init_done = 1; cc_on = 1;
  endtask

  task automatic send_frame();
    frame_end = 1;
    step(1);
    frame_end = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    check("R1 reset done low", done_drive_low, 1'b1);
    check("R1 reset gsr", gsr_active, 1'b1);
    check("R1 reset io", io_enable, 1'b0);
    check("R1 reset clear req", cfg_clear_req, 1'b1);
    rst_n = 1;
    step(2);

    // Default synchronized config-clock mode, frame after the count.
    begin_cfg(2'b01, 5, 0, 0, 0);
    step(12);
    send_frame();
    step(30);
    check("R9 all events", startup_done, 1'b1);

    // Count reached long before the frame.
    begin_cfg(2'b01, 2, 0, 0, 0);
    step(25);
    check("R2 waits for frame", done_drive_low, 1'b1);
    send_frame();
    step(30);
    check("R2 starts after frame", done_drive_low, 1'b0);

    // Frame early, count not yet reached.
    begin_cfg(2'b00, 20, 0, 0, 0);
    send_frame();
    step(12);
    check("R2 waits for count", done_drive_low, 1'b1);
    step(40);
    check("R2 count then start", startup_done, 1'b1);

    // Free-running, reversed order and slot clamp.
    begin_cfg(2'b00, 3, 4, 0, 1);
    send_frame();
    for (int k = 0; k < 60 && !io_enable; k++) step(1);
    check("R11 io before done", done_drive_low, 1'b1);
    step(20);
    check("R5 all fired", startup_done, 1'b1);
    begin_cfg(2'b00, 3, 7, 6, 5);
    send_frame();
    step(30);

    // All three on the same edge.
    begin_cfg(2'b00, 2, 2, 2, 2);
    send_frame();
    for (int k = 0; k < 60 && done_drive_low; k++) step(1);
    check("R11 same edge gsr", gsr_active, 1'b0);
    check("R11 same edge io", io_enable, 1'b1);

    // External hold in synchronized mode.
    ext_hold = 1;
    begin_cfg(2'b01, 3, 0, 3, 1);
    send_frame();
    step(40);
    check("R7 own done released", done_drive_low, 1'b0);
    check("R7 gsr held", gsr_active, 1'b1);
    check("R7 io held", io_enable, 1'b0);
    ext_hold = 0;
    step(30);
    check("R7 resumes", startup_done, 1'b1);

    // User clock mode; later mode_sel change ignored.
    begin_cfg(2'b10, 3, 1, 0, 2);
    uc_on = 0;
    mode_sel = 2'b00;
    send_frame();
    step(40);
    check("R8 config strobe ignored", done_drive_low, 1'b1);
    check("R3 latched mode", cfg_clear_req, 1'b0);
    uc_on = 1;
    step(40);
    check("R3 user strobe used", startup_done, 1'b1);

    // User clock synchronized, partial run then abort.
    begin_cfg(2'b11, 4, 3, 2, 0);
    send_frame();
    step(14);
    prog_n = 0;
    step(1);
    check("R10 abort clears", cfg_clear_req, 1'b1);
    check("R10 abort done low", done_drive_low, 1'b1);
    check("R10 abort gsr", gsr_active, 1'b1);
    begin_cfg(2'b11, 12, 0, 4, 4);
    send_frame();
    step(4);
    check("R10 needs recount", done_drive_low, 1'b1);
    step(80);
    check("R6 sync user done", startup_done, 1'b1);
    uc_on = 0;
    step(2);

    summary();
    $finish;
  end

endmodule